// File: doc/BRIEF.md
# Small Integer Instruction Processor Core

A single-cycle 32-bit processor core that runs a reduced integer instruction set. On every clock it fetches one 32-bit word from an instruction port and decodes it. It reads two operands from a 32-entry register file and does one of these: an arithmetic operation, a compare, a constant build, a load or store, a branch or a jump. On the same rising edge it writes the result back and moves to the next program counter.

Both memory ports carry byte addresses, and each word is 4 bytes. Both ports read combinationally: the word at the address the core presents must be on the read-data input within the same cycle. The ports are plain address/data pins with no handshake. A store is a single-cycle write strobe that takes effect on the rising edge. No back-pressure exists, because each port is assumed to answer every cycle.

The opcode field (bits 31:26) alone sets the instruction layout. The value 0 means register format, with the function code in bits 5:0. The values 2 and 3 mean jump format, with a 26-bit target in bits 25:0. Every other value means immediate format, with a 16-bit immediate in bits 15:0. The source register field is in bits 25:21 and the second register field is in bits 20:16. The register-format destination is in bits 15:11.

Top module: `mini_core`

## Requirements
- R1: Register-format instructions with opcode 0 write rd (bits 15:11). Function 32 writes rs+rt, function 34 writes rs-rt, and function 42 writes 1 if rs < rt as signed numbers and 0 otherwise.
- R2: addi (opcode 8) writes rs plus the sign-extended 16-bit immediate into rt. slti (opcode 10) writes 1 into rt when rs is less than the sign-extended immediate as a signed number, and 0 otherwise.
- R3: lui (opcode 15) writes the immediate into the upper 16 bits of rt and zeros into the lower 16 bits.
- R4: lw (opcode 35) loads rt from address rs + sign-extended immediate. sw (opcode 43) writes rt to that address. dmem_we is high only while a sw is executing.
- R5: beq (opcode 4) and bne (opcode 5) compare rs with rt. When the branch is taken, the next PC is PC+4 plus the sign-extended immediate times 4. When it is not taken, the next PC is PC+4.
- R6: j (opcode 2) and jal (opcode 3) jump to {PC+4[31:28], target, 2'b00}, and jal also writes PC+4 into register 31. jr (opcode 0, function 8) sets the PC to rs.
- R7: Register 0 always reads as zero, and writes to it are discarded.
- R8: While reset is held, imem_addr is 0x00400000 and dmem_we is 0.
- R9: An unrecognised opcode, or an unrecognised function code under opcode 0, writes no register and no memory and advances the PC by 4.
- R10: Every instruction that is not a branch or a jump advances the PC by exactly 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 32 | Byte address of the instruction being executed (the PC) |
| imem_rdata | input | 32 | Instruction word at imem_addr, combinational |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, written on the rising edge |
| dmem_rdata | input | 32 | Load data at dmem_addr, combinational |

## Verification
The assertions assume that imem_rdata always holds the word fetched for the current imem_addr within the same cycle. They also assume that reset is low from time zero. Under these assumptions, the opcode seen at the port is the instruction that decides the next PC. The bench keeps to this by modelling both memories as arrays that are read combinationally. It holds reset low from the start and ends every program with a jump to itself, so the fetch never leaves the loaded region.

// File: rtl/core_pkg.sv
package core_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OPC_REG  = 6'd0;
  localparam logic [5:0] OPC_J    = 6'd2;
  localparam logic [5:0] OPC_JAL  = 6'd3;
  localparam logic [5:0] OPC_BEQ  = 6'd4;
  localparam logic [5:0] OPC_BNE  = 6'd5;
  localparam logic [5:0] OPC_ADDI = 6'd8;
  localparam logic [5:0] OPC_SLTI = 6'd10;
  localparam logic [5:0] OPC_LUI  = 6'd15;
  localparam logic [5:0] OPC_LW   = 6'd35;
  localparam logic [5:0] OPC_SW   = 6'd43;

  localparam logic [5:0] FN_JR  = 6'd8;
  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_SLT, ALU_HI} alu_fn_e;
  typedef enum logic [2:0] {NPC_SEQ, NPC_BEQ, NPC_BNE, NPC_JMP, NPC_REG} npc_e;
  typedef enum logic [1:0] {DST_RD, DST_RT, DST_LINK} dst_e;
  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LINK} wb_e;

  typedef struct packed {
    logic    reg_we;
    logic    mem_we;
    logic    use_imm;
    alu_fn_e alu_fn;
    dst_e    dst;
    wb_e     wb;
    npc_e    npc;
  } ctrl_t;
endpackage

// File: rtl/core_decode.sv
module core_decode
  import core_pkg::*;
(
  input  logic [31:0] instr,
  output ctrl_t       ctrl
);
  logic [5:0] opc;
  logic [5:0] fn;
  assign opc = instr[31:26];
  assign fn  = instr[5:0];

  always_comb begin
    ctrl         = '0;
    ctrl.alu_fn  = ALU_ADD;
    ctrl.dst     = DST_RT;
    ctrl.wb      = WB_ALU;
    ctrl.npc     = NPC_SEQ;
    case (opc)
      OPC_REG: begin
        ctrl.dst = DST_RD;
        case (fn)
          FN_ADD: begin ctrl.reg_we = 1'b1; ctrl.alu_fn = ALU_ADD; end
          FN_SUB: begin ctrl.reg_we = 1'b1; ctrl.alu_fn = ALU_SUB; end
          FN_SLT: begin ctrl.reg_we = 1'b1; ctrl.alu_fn = ALU_SLT; end
          FN_JR:  ctrl.npc = NPC_REG;
          default: ;
        endcase
      end
      OPC_ADDI: begin ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; end
      OPC_SLTI: begin ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu_fn = ALU_SLT; end
      OPC_LUI:  begin ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu_fn = ALU_HI; end
      OPC_LW:   begin ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.wb = WB_MEM; end
      OPC_SW:   begin ctrl.mem_we = 1'b1; ctrl.use_imm = 1'b1; end
      OPC_BEQ:  ctrl.npc = NPC_BEQ;
      OPC_BNE:  ctrl.npc = NPC_BNE;
      OPC_J:    ctrl.npc = NPC_JMP;
      OPC_JAL: begin
        ctrl.npc    = NPC_JMP;
        ctrl.reg_we = 1'b1;
        ctrl.dst    = DST_LINK;
        ctrl.wb     = WB_LINK;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr_a,
  input  logic [AW-1:0]    raddr_b,
  output logic [WIDTH-1:0] rdata_a,
  output logic [WIDTH-1:0] rdata_b
);
  logic [WIDTH-1:0] cells [1:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we && waddr != '0) cells[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : cells[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : cells[raddr_b];
endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int HALF = WIDTH / 2
) (
  input  alu_fn_e          fn,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] y
);
  always_comb begin
    case (fn)
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(WIDTH-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_HI:  y = {b[HALF-1:0], {HALF{1'b0}}};
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/mini_core.sv
module mini_core
  import core_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0040_0000,
  parameter int          NREGS    = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata
);
  localparam int AW = $clog2(NREGS);
  localparam logic [AW-1:0] LINK_REG = AW'(NREGS - 1);

  logic [31:0] pc_q, pc_next, pc_inc, br_tgt, jmp_tgt;
  logic [31:0] imm_sx, rs_val, rt_val, alu_b, alu_y, wb_val;
  logic [AW-1:0] rs_idx, rt_idx, rd_idx, wr_idx;
  ctrl_t ctrl;

  assign rs_idx = imem_rdata[25:21];
  assign rt_idx = imem_rdata[20:16];
  assign rd_idx = imem_rdata[15:11];
  assign imm_sx = {{16{imem_rdata[15]}}, imem_rdata[15:0]};

  core_decode u_dec (.instr(imem_rdata), .ctrl(ctrl));

  always_comb begin
    case (ctrl.dst)
      DST_RD:   wr_idx = rd_idx;
      DST_LINK: wr_idx = LINK_REG;
      default:  wr_idx = rt_idx;
    endcase
  end

  core_regfile #(.WIDTH(XLEN), .DEPTH(NREGS)) u_rf (
    .clk     (clk),
    .we      (ctrl.reg_we & rst_n),
    .waddr   (wr_idx),
    .wdata   (wb_val),
    .raddr_a (rs_idx),
    .raddr_b (rt_idx),
    .rdata_a (rs_val),
    .rdata_b (rt_val)
  );

  assign alu_b = ctrl.use_imm ? imm_sx : rt_val;

  core_alu #(.WIDTH(XLEN)) u_alu (.fn(ctrl.alu_fn), .a(rs_val), .b(alu_b), .y(alu_y));

  assign pc_inc  = pc_q + 32'd4;
  assign br_tgt  = pc_inc + {imm_sx[29:0], 2'b00};
  assign jmp_tgt = {pc_inc[31:28], imem_rdata[25:0], 2'b00};

  always_comb begin
    case (ctrl.wb)
      WB_MEM:  wb_val = dmem_rdata;
      WB_LINK: wb_val = pc_inc;
      default: wb_val = alu_y;
    endcase
  end

  always_comb begin
    case (ctrl.npc)
      NPC_BEQ: pc_next = (rs_val == rt_val) ? br_tgt : pc_inc;
      NPC_BNE: pc_next = (rs_val != rt_val) ? br_tgt : pc_inc;
      NPC_JMP: pc_next = jmp_tgt;
      NPC_REG: pc_next = rs_val;
      default: pc_next = pc_inc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= RESET_PC;
    else        pc_q <= pc_next;
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctrl.mem_we & rst_n;
endmodule

// File: rtl/mini_core_chk.sv
module mini_core_chk #(
  parameter logic [31:0] RESET_PC = 32'h0040_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] imem_addr,
  input logic [31:0] imem_rdata,
  input logic        dmem_we
);
  logic [5:0]  op;
  logic [31:0] seq_pc, rel_pc, abs_pc;
  logic        plain;

  assign op     = imem_rdata[31:26];
  assign seq_pc = imem_addr + 32'd4;
  assign rel_pc = seq_pc + {{14{imem_rdata[15]}}, imem_rdata[15:0], 2'b00};
  assign abs_pc = {seq_pc[31:28], imem_rdata[25:0], 2'b00};
  assign plain  = !(op inside {6'd2, 6'd3, 6'd4, 6'd5}) &&
                  !(op == 6'd0 && imem_rdata[5:0] == 6'd8);

  // R8
  reset_pc_chk: assert property (@(posedge clk) !rst_n |=> imem_addr == RESET_PC);

  // R4
  store_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> op == 6'd43);

  // R10
  seq_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    plain |=> imem_addr == $past(seq_pc));

  // R5
  branch_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 6'd4 || op == 6'd5) |=> (imem_addr == $past(seq_pc) || imem_addr == $past(rel_pc)));

  // R6
  jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 6'd2 || op == 6'd3) |=> imem_addr == $past(abs_pc));

  // R10
  word_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    imem_addr[1:0] == 2'b00);
endmodule

bind mini_core mini_core_chk #(.RESET_PC(RESET_PC)) u_chk (
  .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr),
  .imem_rdata(imem_rdata), .dmem_we(dmem_we)
);

// File: tb/mini_core_test.sv
module mini_core_test;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] BASE       = 32'h0040_0000;
  localparam int          WDOG       = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] imem [0:63];
  logic [31:0] dmem [0:63];
  logic [31:0] ioff;
  int ip;
  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mini_core uut (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata)
  );

  assign ioff       = imem_addr - BASE;
  assign imem_rdata = imem[ioff[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG) begin
      misses++;
      $display("FAIL watchdog: got %0d cycles expected fewer than %0d", cycles, WDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  function automatic logic [31:0] r_op(int rs, int rt, int rd, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction
  function automatic logic [31:0] i_op(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] j_op(int op, logic [31:0] dest);
    return {6'(op), dest[27:2]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic emit(logic [31:0] w);
    imem[ip] = w;
    ip++;
  endtask

  task automatic halt();
    emit(j_op(2, BASE + 32'(ip) * 4));
  endtask

  task automatic fresh();
    for (int k = 0; k < 64; k++) begin imem[k] = 32'd0; dmem[k] = 32'd0; end
    ip = 0;
  endtask

  task automatic restart();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic run(int n);
    restart();
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    fresh();
    halt();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 reset pc", imem_addr, BASE);
    chk("R8 reset no store", 32'(dmem_we), 32'd0);
  endtask

  task automatic t_arith();
    fresh();
    emit(i_op(8, 0, 1, 5));
    emit(i_op(8, 0, 2, -3));
    emit(r_op(1, 2, 3, 32));
    emit(r_op(1, 2, 4, 34));
    emit(r_op(2, 1, 5, 42));
    emit(r_op(1, 2, 6, 42));
    emit(i_op(10, 2, 7, -2));
    emit(i_op(10, 1, 8, -1));
    emit(i_op(15, 0, 9, 15));
    emit(i_op(15, 0, 10, 1));
    emit(i_op(8, 10, 10, 14464));
    emit(i_op(8, 0, 0, 7));
    for (int k = 2; k <= 10; k++) emit(i_op(43, 0, k, (k - 2) * 4));
    emit(i_op(43, 0, 0, 36));
    halt();
    dmem[9] = 32'hDEAD_BEEF;
    run(40);
    chk("R2 addi negative", dmem[0], 32'hFFFF_FFFD);
    chk("R1 add", dmem[1], 32'd2);
    chk("R1 sub", dmem[2], 32'd8);
    chk("R1 slt true signed", dmem[3], 32'd1);
    chk("R1 slt false signed", dmem[4], 32'd0);
    chk("R2 slti true", dmem[5], 32'd1);
    chk("R2 slti false", dmem[6], 32'd0);
    chk("R3 lui 15", dmem[7], 32'h000F_0000);
    chk("R3 lui plus addi", dmem[8], 32'd80000);
    chk("R7 r0 reads zero", dmem[9], 32'd0);
  endtask

  task automatic t_mem();
    fresh();
    emit(i_op(8, 0, 1, 40));
    emit(i_op(35, 1, 2, 0));
    emit(i_op(35, 1, 3, -4));
    emit(i_op(43, 1, 2, 4));
    emit(i_op(43, 0, 3, 16));
    halt();
    dmem[9] = 32'hCAFE_F00D;
    dmem[10] = 32'h1234_5678;
    dmem[12] = 32'h5555_5555;
    run(20);
    chk("R4 lw then sw offset", dmem[11], 32'h1234_5678);
    chk("R4 lw negative offset", dmem[4], 32'hCAFE_F00D);
    chk("R4 source word kept", dmem[10], 32'h1234_5678);
    chk("R4 neighbour untouched", dmem[12], 32'h5555_5555);
  endtask

  task automatic t_branch(int mlier, int mcand);
    fresh();
    emit(i_op(8, 0, 4, mcand));
    emit(i_op(8, 0, 5, mlier));
    emit(r_op(0, 0, 2, 32));
    emit(r_op(0, 5, 9, 42));
    emit(i_op(4, 9, 0, 4));
    emit(r_op(2, 4, 2, 32));
    emit(i_op(8, 5, 5, -1));
    emit(r_op(0, 5, 9, 42));
    emit(i_op(5, 9, 0, -4));
    emit(i_op(43, 0, 2, 0));
    emit(i_op(4, 0, 0, 1));
    emit(i_op(8, 0, 2, 99));
    emit(i_op(5, 0, 0, 1));
    emit(i_op(8, 0, 6, 55));
    emit(i_op(43, 0, 2, 4));
    emit(i_op(43, 0, 6, 8));
    halt();
    run(80);
    chk("R5 loop product", dmem[0], 32'(mlier * mcand));
    chk("R5 beq taken skips", dmem[1], 32'(mlier * mcand));
    chk("R5 bne not taken falls through", dmem[2], 32'd55);
  endtask

  task automatic t_jump();
    fresh();
    emit(i_op(8, 0, 1, 1));
    emit(j_op(3, BASE + 32'd20));
    emit(i_op(8, 1, 1, 100));
    emit(j_op(2, BASE + 32'd32));
    emit(i_op(8, 0, 1, 999));
    emit(i_op(8, 1, 1, 10));
    emit(i_op(43, 0, 31, 4));
    emit(r_op(31, 0, 0, 8));
    emit(i_op(43, 0, 1, 0));
    halt();
    restart();
    @(posedge clk); @(negedge clk);
    chk("R10 pc after addi", imem_addr, BASE + 32'd4);
    @(posedge clk); @(negedge clk);
    chk("R6 jal target", imem_addr, BASE + 32'd20);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk("R6 jal link value", dmem[1], BASE + 32'd8);
    chk("R6 jr return and j", dmem[0], 32'd111);
  endtask

  task automatic t_unknown();
    fresh();
    emit(i_op(8, 0, 8, 291));
    emit(i_op(63, 0, 8, 5));
    emit(r_op(0, 0, 8, 63));
    emit(r_op(0, 0, 8, 0));
    emit(i_op(43, 0, 8, 0));
    halt();
    dmem[1] = 32'h77;
    restart();
    @(posedge clk); @(negedge clk);
    chk("R9 pc at unknown op", imem_addr, BASE + 32'd4);
    chk("R9 no store on unknown op", 32'(dmem_we), 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R9 unknown op advances 4", imem_addr, BASE + 32'd8);
    @(posedge clk); @(negedge clk);
    chk("R9 unknown funct advances 4", imem_addr, BASE + 32'd12);
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk("R9 rt and rd not written", dmem[0], 32'd291);
    chk("R9 memory untouched", dmem[1], 32'h77);
  endtask

  initial begin
    t_reset();
    t_arith();
    t_mem();
    t_branch(3, 7);
    t_branch(0, 7);
    t_branch(5, -2);
    t_jump();
    t_unknown();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule